// File: doc/BRIEF.md
# Execute-Only Region Access Checker

This block screens every flash command request against four execute-only code regions and returns an allow or deny decision in the same cycle as the request strobe. Each region is described by a base field, a size counted in pages and an active bit. The base field holds address bits [31:8], so a region starts at `{base, 8'h00}` and covers `size * PAGE_BYTES` bytes. A region with size zero covers nothing.

Commands that land inside an active region are refused. The two checksum commands are always let through. A region page erase is also exempt, but only when its address equals the start of the matched region. Any other page erase aimed inside the region is treated as a setup mismatch and refused. A registered status bit records whether the most recent page erase that hit a region was refused, so software knows to retry the erase. When regions overlap, the lowest-numbered matching region decides the result and is the one reported.

Top module: `xom_access_guard`

## Requirements
- R1: A region whose active bit is 0 never produces a hit or a deny, whatever the command or address.
- R2: An address hits region k when start_k <= addr < start_k + size_k*PAGE_BYTES, where start_k = {base_k, 8'h00}. The end bound is exclusive, and a region of size 0 never hits.
- R3: A request with req_valid_i=1 whose command is not exempt and whose address hits an active region drives deny_o=1 in the same cycle.
- R4: Requests with the checksum command codes 7'h0D (read result) or 7'h2D (run calculation) are never denied.
- R5: A page erase (command 7'h22) is allowed when its address equals the start of the selected region, and is denied otherwise.
- R6: When several active regions hit, hit_idx_o reports the lowest-numbered one, and the page-erase base comparison in R5 uses that region.
- R7: With req_valid_i=0, deny_o, hit_valid_o and hit_idx_o are all 0.
- R8: erase_fail_o resets to 0. One clock after a valid page erase that hits a region, it takes the value of that request's deny. It is otherwise unchanged.
- R9: A request whose address hits no active region is allowed for any command, and hit_valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_cmd_i | input | 7 | Command code |
| req_addr_i | input | 32 | Target byte address |
| region_base_i | input | 96 | Four base fields, 24 bits each, region 0 in the low bits |
| region_size_i | input | 32 | Four size fields in pages, 8 bits each, region 0 in the low bits |
| region_active_i | input | 4 | Active bit per region |
| deny_o | output | 1 | Request refused (combinational) |
| hit_valid_o | output | 1 | Request address hit an active region |
| hit_idx_o | output | 2 | Lowest-numbered region hit |
| erase_fail_o | output | 1 | Last region page erase was refused |

## Verification
The decision path has no state, so a wrong range compare or a wrong priority shows up as a wrong deny_o or hit_idx_o in the very cycle the request is presented. The overlapping-region and end-boundary stimuli expose these errors. The only register is the erase failure bit, which shows its error one clock after a region page erase. A wrongly held or wrongly cleared value then persists through later unrelated requests, and the bench compares it on every clock. Each comparison is made against a behavioural model that walks the region list with integer arithmetic.

// File: rtl/xom_pkg.sv
package xom_pkg;

    localparam int NUM_REGIONS = 4;
    localparam int ADDR_W      = 32;
    localparam int BASE_W      = 24;
    localparam int SIZE_W      = 8;
    localparam int CMD_W       = 7;
    localparam int IDX_W       = $clog2(NUM_REGIONS);

    typedef enum logic [CMD_W-1:0] {
        CMD_READ       = 7'h00,
        CMD_SUM_READ   = 7'h0D,
        CMD_PROGRAM    = 7'h21,
        CMD_PAGE_ERASE = 7'h22,
        CMD_SUM_RUN    = 7'h2D
    } cmd_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic              active;
    } region_cfg_t;

    typedef struct packed {
        logic             deny;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } verdict_t;

    function automatic logic is_checksum(input logic [CMD_W-1:0] c);
        return (c == CMD_SUM_READ) || (c == CMD_SUM_RUN);
    endfunction

    function automatic logic is_page_erase(input logic [CMD_W-1:0] c);
        return c == CMD_PAGE_ERASE;
    endfunction

endpackage

// File: rtl/xom_region_match.sv
module xom_region_match #(
    parameter int ADDR_W     = 32,
    parameter int BASE_W     = 24,
    parameter int SIZE_W     = 8,
    parameter int PAGE_SHIFT = 11
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              active_i,
    output logic              hit_o,
    output logic              at_start_o
);
    localparam int LOW_W = ADDR_W - BASE_W;
    localparam int PAD_W = ADDR_W + 1 - SIZE_W;

    logic [ADDR_W:0] start_x;
    logic [ADDR_W:0] span_x;
    logic [ADDR_W:0] end_x;
    logic [ADDR_W:0] addr_x;

    always_comb begin
        start_x    = {1'b0, base_i, {LOW_W{1'b0}}};
        span_x     = {{PAD_W{1'b0}}, size_i} << PAGE_SHIFT;
        end_x      = start_x + span_x;
        addr_x     = {1'b0, addr_i};
        hit_o      = active_i && (size_i != '0) &&
                     (addr_x >= start_x) && (addr_x < end_x);
        at_start_o = (addr_x == start_x);
    end

endmodule

// File: rtl/xom_prio_pick.sv
module xom_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/xom_erase_status.sv
module xom_erase_status (
    input  logic clk,
    input  logic rst,
    input  logic pe_seen_i,
    input  logic pe_denied_i,
    output logic fail_o
);
    always_ff @(posedge clk) begin
        if (rst)            fail_o <= 1'b0;
        else if (pe_seen_i) fail_o <= pe_denied_i;
    end

    a_r8_fail_follows: assert property (@(posedge clk) disable iff (rst)
        pe_seen_i |=> (fail_o == $past(pe_denied_i)));

    a_r8_fail_holds: assert property (@(posedge clk) disable iff (rst)
        !pe_seen_i |=> $stable(fail_o));

endmodule

// File: rtl/xom_access_guard.sv
module xom_access_guard
    import xom_pkg::*;
#(
    parameter int PAGE_BYTES = 2048
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid_i,
    input  logic [CMD_W-1:0]              req_cmd_i,
    input  logic [ADDR_W-1:0]             req_addr_i,
    input  logic [NUM_REGIONS*BASE_W-1:0] region_base_i,
    input  logic [NUM_REGIONS*SIZE_W-1:0] region_size_i,
    input  logic [NUM_REGIONS-1:0]        region_active_i,
    output logic                          deny_o,
    output logic                          hit_valid_o,
    output logic [IDX_W-1:0]              hit_idx_o,
    output logic                          erase_fail_o
);
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

    region_cfg_t            cfg [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hit_vec;
    logic [NUM_REGIONS-1:0] start_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       sel_idx;
    verdict_t               verdict;
    logic                   pe_seen;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        always_comb begin
            cfg[g].base   = region_base_i[g*BASE_W +: BASE_W];
            cfg[g].size   = region_size_i[g*SIZE_W +: SIZE_W];
            cfg[g].active = region_active_i[g];
        end

        xom_region_match #(
            .ADDR_W    (ADDR_W),
            .BASE_W    (BASE_W),
            .SIZE_W    (SIZE_W),
            .PAGE_SHIFT(PAGE_SHIFT)
        ) u_match (
            .addr_i    (req_addr_i),
            .base_i    (cfg[g].base),
            .size_i    (cfg[g].size),
            .active_i  (cfg[g].active),
            .hit_o     (hit_vec[g]),
            .at_start_o(start_vec[g])
        );
    end

    xom_prio_pick #(
        .N    (NUM_REGIONS),
        .IDX_W(IDX_W)
    ) u_pick (
        .req_i(hit_vec),
        .any_o(any_hit),
        .idx_o(sel_idx)
    );

    always_comb begin
        verdict.hit  = req_valid_i && any_hit;
        verdict.idx  = verdict.hit ? sel_idx : '0;
        verdict.deny = verdict.hit && !is_checksum(req_cmd_i) &&
                       !(is_page_erase(req_cmd_i) && start_vec[sel_idx]);
        pe_seen      = verdict.hit && is_page_erase(req_cmd_i);
    end

    assign deny_o      = verdict.deny;
    assign hit_valid_o = verdict.hit;
    assign hit_idx_o   = verdict.idx;

    xom_erase_status u_status (
        .clk        (clk),
        .rst        (rst),
        .pe_seen_i  (pe_seen),
        .pe_denied_i(verdict.deny),
        .fail_o     (erase_fail_o)
    );

    a_r3_deny_needs_hit: assert property (@(posedge clk) disable iff (rst)
        deny_o |-> hit_valid_o);

    a_r4_checksum_passes: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && is_checksum(req_cmd_i)) |-> !deny_o);

    a_r1_hit_is_active: assert property (@(posedge clk) disable iff (rst)
        hit_valid_o |-> region_active_i[hit_idx_o]);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |-> (!deny_o && !hit_valid_o && hit_idx_o == '0));

endmodule

// File: tb/xom_access_guard_bench.sv
module xom_access_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [6:0]  req_cmd_i = '0;
    logic [31:0] req_addr_i = '0;
    logic [95:0] region_base_i = '0;
    logic [31:0] region_size_i = '0;
    logic [3:0]  region_active_i = '0;
    logic        deny_o;
    logic        hit_valid_o;
    logic [1:0]  hit_idx_o;
    logic        erase_fail_o;

    int checks = 0;
    int errors = 0;
    bit model_fail = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xom_access_guard u_xom_access_guard (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i),
        .region_base_i(region_base_i), .region_size_i(region_size_i),
        .region_active_i(region_active_i),
        .deny_o(deny_o), .hit_valid_o(hit_valid_o), .hit_idx_o(hit_idx_o),
        .erase_fail_o(erase_fail_o)
    );

    task automatic set_region(input int k, input int base, input int size, input bit act);
        region_base_i[k*24 +: 24] = base[23:0];
        region_size_i[k*8 +: 8]   = size[7:0];
        region_active_i[k]        = act;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int cmd, input longint addr, input string tag);
        bit e_hit, e_deny, pe_hit;
        int e_idx;
        longint s, e;
        @(negedge clk);
        req_valid_i = v;
        req_cmd_i   = cmd[6:0];
        req_addr_i  = addr[31:0];
        #1;
        e_hit = 0; e_idx = 0; e_deny = 0;
        if (v) begin
            for (int k = 0; k < 4 && !e_hit; k++) begin
                s = longint'(region_base_i[k*24 +: 24]) * 256;
                e = s + longint'(region_size_i[k*8 +: 8]) * 2048;
                if (region_active_i[k] && addr >= s && addr < e) begin
                    e_hit = 1; e_idx = k;
                    if (cmd == 'h0D || cmd == 'h2D) e_deny = 0;
                    else if (cmd == 'h22) e_deny = (addr != s);
                    else e_deny = 1;
                end
            end
        end
        cmp(tag, "deny", deny_o, e_deny);
        cmp(tag, "hit_valid", hit_valid_o, e_hit);
        cmp(tag, "hit_idx", hit_idx_o, e_idx);
        cmp(tag, "erase_fail", erase_fail_o, model_fail);
        pe_hit = v && e_hit && cmd == 'h22;
        @(posedge clk);
        if (pe_hit) model_fail = e_deny;
    endtask

    initial begin
        set_region(0, 'h000100, 2, 1);
        set_region(1, 'h000200, 4, 1);
        set_region(2, 'h000300, 1, 0);
        set_region(3, 'h000108, 4, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(0, 'h00, 'h10000, "R8_reset");
        step(1, 'h00, 'h10000, "R3_read_base");
        step(1, 'h21, 'h10FFC, "R6_overlap_low");
        step(1, 'h00, 'h11000, "R2_region3_only");
        step(1, 'h00, 'h12800, "R2_end_exclusive");
        step(1, 'h21, 'h0FFFC, "R9_below_start");
        step(1, 'h21, 'h30000, "R1_inactive");
        step(1, 'h2D, 'h20000, "R4_sum_run");
        step(1, 'h0D, 'h21000, "R4_sum_read");
        step(1, 'h22, 'h20800, "R5_erase_mismatch");
        step(1, 'h00, 'h00000, "R8_fail_held");
        step(1, 'h22, 'h20000, "R5_erase_base");
        step(1, 'h00, 'h00000, "R8_fail_cleared");
        step(0, 'h21, 'h20000, "R7_no_request");
        step(1, 'h22, 'h10800, "R6_erase_uses_low");
        step(1, 'h22, 'h50000, "R9_erase_outside");
        step(1, 'h21, 'h21FFC, "R3_program_top");
        set_region(1, 'h000200, 0, 1);
        step(1, 'h00, 'h20000, "R2_size_zero");
        set_region(2, 'h000300, 1, 1);
        step(1, 'h00, 'h307FC, "R1_now_active");
        step(1, 'h22, 'h30000, "R5_erase_clear");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_fail = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        step(0, 'h00, 'h0, "R8_reset_again");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule